// File: doc/BRIEF.md
# DMA Command Byte Sequencer

This block sits behind the single write port of a one-channel DMA controller. Every byte the CPU writes to that port arrives on `wr_data` with a one-cycle `wr_en` strobe. When no parameter bytes are pending, the byte is a base byte. The block matches it against fixed bit patterns to pick one of seven write-register groups. Flag bits in the base byte then say which parameter bytes follow. Those bytes are taken strictly from the lowest flag bit to the highest. One group also carries a nested follow-on: a flag inside a parameter byte can call for one more byte.

The decoded fields are held in registers that the transfer engine reads continuously: port addresses, block length, direction, port kind, address step, cycle timing, prescaler, mode and restart options, and the read mask. Command codes on the command group become single-cycle pulses to the engine: reset, timing resets, load, continue, enable, disable and the status and read-sequence commands. The transfer datapath and register read-back belong to other blocks.

Top module: `dma_cmd_seq`

## Requirements
- R1: With nothing pending, a base byte selects a group by these patterns, where x is any bit: group 0 = 0xxxxxAA with AA not 00; group 1 = 0xxxx100; group 2 = 0xxxx000; group 3 = 1xxxxx00; group 4 = 1xxxxx01; group 5 = 10xxx010; group 6 = 1xxxxx11. A byte that matches none of them (1xxxxx10 outside group 5) changes no output and raises no pulse.
- R2: In group 0, bit 2 sets `dir_a_to_b` (1 = port A to port B). Bits 3, 4, 5 and 6 flag, in that order, the following bytes: port A address low, port A address high, length low and length high. Only the flagged bytes are expected.
- R3: In groups 1 and 2, bit 3 sets the port's IO flag and bits 5:4 set its step code. Bit 6 flags a timing byte, whose bits 1:0 become the port's cycle code.
- R4: In the group 2 timing byte, bit 5 flags one more byte after it, which becomes `prescale`.
- R5: In group 4, bits 2 and 3 flag the port B address low and high bytes. `burst_mode` is 1 only when bits 6:5 are 10. The codes 01, 00 and 11 all give continuous mode (0).
- R6: In group 5, bit 5 sets `auto_restart` and bit 4 sets `ce_wait_mux`.
- R7: Group 6 codes raise their own output for exactly the cycle after the write: 0xC3 reset, 0xC7 port A timing reset, 0xCB port B timing reset, 0xCF load, 0xD3 continue, 0x87 enable, 0x83 disable, 0xBF read status, 0x8B reinitialise status, 0xA7 start read sequence. Any other code raises no pulse. No more than one pulse is high in any cycle.
- R8: Code 0xBB makes the next byte the read mask, whose bits 6:0 go to `read_mask`. After `rst_n`, `read_mask` is 0x7F. The mask changes only in the cycle after a write.
- R9: A timing or prescaler byte that is not flagged leaves the stored value unchanged. 0xC3 clears both cycle codes and the prescaler. 0xC7 clears the port A cycle code. 0xCB clears the port B cycle code and the prescaler.
- R10: In group 3, bit 6 raises `cmd_enable`. Bits 3 and 4 flag two parameter bytes that are accepted and then discarded.
- R11: After the last expected parameter byte, the next byte is decoded as a base byte again. A parameter byte whose value equals a command code is stored as data and never executed.
- R12: While `rst_n` is low, all addresses, the length, the codes, the flags and the prescaler clear to 0, `read_mask` goes to 0x7F, and all pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one byte |
| wr_data | input | DATA_W | Written byte |
| dir_a_to_b | output | 1 | Transfer direction, 1 = A to B |
| porta_addr | output | 2*DATA_W | Port A start address |
| block_len | output | 2*DATA_W | Block length |
| porta_io | output | 1 | Port A is IO space |
| porta_step | output | 2 | Port A step code |
| porta_cycles | output | 2 | Port A cycle code |
| portb_io | output | 1 | Port B is IO space |
| portb_step | output | 2 | Port B step code |
| portb_cycles | output | 2 | Port B cycle code |
| portb_addr | output | 2*DATA_W | Port B start address |
| prescale | output | PRESC_W | Fixed-time transfer prescaler |
| burst_mode | output | 1 | 1 = burst, 0 = continuous |
| auto_restart | output | 1 | Restart at end of block |
| ce_wait_mux | output | 1 | Combined chip-enable/wait mode |
| read_mask | output | MASK_W | Read-back mask |
| cmd_reset | output | 1 | Reset pulse |
| cmd_reset_ta | output | 1 | Port A timing reset pulse |
| cmd_reset_tb | output | 1 | Port B timing reset pulse |
| cmd_load | output | 1 | Load pulse |
| cmd_continue | output | 1 | Continue pulse |
| cmd_enable | output | 1 | Enable pulse |
| cmd_disable | output | 1 | Disable pulse |
| cmd_rd_status | output | 1 | Read status pulse |
| cmd_reinit_status | output | 1 | Reinitialise status pulse |
| cmd_rd_seq | output | 1 | Start read sequence pulse |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, a 7-bit read mask and an 8-bit prescaler. With these values, every base pattern, every flag combination and the nested prescaler byte can be driven with real byte values. Streams of full, partial and empty flag sets are used, together with bytes that look like commands but sit in parameter positions. These streams check that each follow-on byte lands in the right field. They also check that decoding returns to base bytes at the right point.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
   timeunit 1ns;
   timeprecision 100ps;

   typedef enum logic [2:0] {
      GRP_NONE, GRP0, GRP1, GRP2, GRP3, GRP4, GRP5, GRP6
   } grp_e;

   // parameter slots; within one group the index order is the arrival order
   localparam int NSLOT  = 12;
   localparam int SLOT_W = 4;
   localparam logic [SLOT_W-1:0] S_A_LO  = 4'd0;
   localparam logic [SLOT_W-1:0] S_A_HI  = 4'd1;
   localparam logic [SLOT_W-1:0] S_L_LO  = 4'd2;
   localparam logic [SLOT_W-1:0] S_L_HI  = 4'd3;
   localparam logic [SLOT_W-1:0] S_TIM_A = 4'd4;
   localparam logic [SLOT_W-1:0] S_TIM_B = 4'd5;
   localparam logic [SLOT_W-1:0] S_PRESC = 4'd6;
   localparam logic [SLOT_W-1:0] S_B_LO  = 4'd7;
   localparam logic [SLOT_W-1:0] S_B_HI  = 4'd8;
   localparam logic [SLOT_W-1:0] S_RMASK = 4'd9;
   localparam logic [SLOT_W-1:0] S_G3_A  = 4'd10;
   localparam logic [SLOT_W-1:0] S_G3_B  = 4'd11;

   typedef struct packed {
      logic rst_all;
      logic rst_ta;
      logic rst_tb;
      logic load;
      logic resume;
      logic en;
      logic dis;
      logic rd_stat;
      logic re_stat;
      logic rd_seq;
   } puls_t;

   typedef struct packed {
      puls_t p;
      logic  mask_nxt;
   } cmd_t;
endpackage

// File: rtl/dcs_base_decode.sv
module dcs_base_decode
   import dcs_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] base,
   output grp_e              grp
);
   timeunit 1ns;
   timeprecision 100ps;

   always_comb begin
      grp = GRP_NONE;
      if (!base[7]) begin
         if (base[1:0] != 2'b00) grp = GRP0;
         else if (base[2])       grp = GRP1;
         else                    grp = GRP2;
      end else begin
         case (base[1:0])
            2'b00: grp = GRP3;
            2'b01: grp = GRP4;
            2'b11: grp = GRP6;
            default: if (!base[6] && base[2:0] == 3'b010) grp = GRP5;
         endcase
      end
   end
endmodule

// File: rtl/dcs_cmd_decode.sv
module dcs_cmd_decode
   import dcs_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              valid,
   input  logic [DATA_W-1:0] code,
   output cmd_t              cmd
);
   timeunit 1ns;
   timeprecision 100ps;

   always_comb begin
      cmd = '0;
      if (valid) begin
         case (code[7:0])
            8'hC3: cmd.p.rst_all = 1'b1;
            8'hC7: cmd.p.rst_ta  = 1'b1;
            8'hCB: cmd.p.rst_tb  = 1'b1;
            8'hCF: cmd.p.load    = 1'b1;
            8'hD3: cmd.p.resume  = 1'b1;
            8'h87: cmd.p.en      = 1'b1;
            8'h83: cmd.p.dis     = 1'b1;
            8'hBF: cmd.p.rd_stat = 1'b1;
            8'h8B: cmd.p.re_stat = 1'b1;
            8'hA7: cmd.p.rd_seq  = 1'b1;
            8'hBB: cmd.mask_nxt  = 1'b1;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/dcs_slot_pick.sv
module dcs_slot_pick #(
   parameter int N  = 12,
   parameter int IW = 4
) (
   input  logic [N-1:0]  pend,
   output logic [IW-1:0] idx,
   output logic          any
);
   timeunit 1ns;
   timeprecision 100ps;

   // lowest pending slot wins
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--)
         if (pend[i]) idx = IW'(i);
   end
   assign any = |pend;
endmodule

// File: rtl/dma_cmd_seq.sv
module dma_cmd_seq
   import dcs_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int MASK_W  = 7,
   parameter int PRESC_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [DATA_W-1:0]   wr_data,
   output logic                dir_a_to_b,
   output logic [2*DATA_W-1:0] porta_addr,
   output logic [2*DATA_W-1:0] block_len,
   output logic                porta_io,
   output logic [1:0]          porta_step,
   output logic [1:0]          porta_cycles,
   output logic                portb_io,
   output logic [1:0]          portb_step,
   output logic [1:0]          portb_cycles,
   output logic [2*DATA_W-1:0] portb_addr,
   output logic [PRESC_W-1:0]  prescale,
   output logic                burst_mode,
   output logic                auto_restart,
   output logic                ce_wait_mux,
   output logic [MASK_W-1:0]   read_mask,
   output logic                cmd_reset,
   output logic                cmd_reset_ta,
   output logic                cmd_reset_tb,
   output logic                cmd_load,
   output logic                cmd_continue,
   output logic                cmd_enable,
   output logic                cmd_disable,
   output logic                cmd_rd_status,
   output logic                cmd_reinit_status,
   output logic                cmd_rd_seq
);
   timeunit 1ns;
   timeprecision 100ps;

   localparam int AW = 2 * DATA_W;
   localparam logic [NSLOT-1:0] SLOT_ONE = {{(NSLOT-1){1'b0}}, 1'b1};
   localparam logic [MASK_W-1:0] MASK_RST = {MASK_W{1'b1}};

   // elaboration-time parameter checks
   generate
      if (DATA_W != 8) begin : g_bad_data
         $error("dma_cmd_seq: bit patterns require DATA_W == 8");
      end
      if (MASK_W < 1 || MASK_W >= DATA_W) begin : g_bad_mask
         $error("dma_cmd_seq: MASK_W must lie in 1..DATA_W-1");
      end
      if (PRESC_W < 1 || PRESC_W > DATA_W) begin : g_bad_presc
         $error("dma_cmd_seq: PRESC_W must lie in 1..DATA_W");
      end
   endgenerate

   logic [NSLOT-1:0]  pend_q, new_pend;
   logic [SLOT_W-1:0] slot_idx;
   logic              pend_any;
   grp_e              grp;
   cmd_t              cmd;
   puls_t             puls_q;

   dcs_slot_pick #(.N(NSLOT), .IW(SLOT_W)) u_pick (
      .pend(pend_q), .idx(slot_idx), .any(pend_any)
   );

   dcs_base_decode #(.DATA_W(DATA_W)) u_base (
      .base(wr_data), .grp(grp)
   );

   dcs_cmd_decode #(.DATA_W(DATA_W)) u_cmd (
      .valid(wr_en && !pend_any && grp == GRP6), .code(wr_data), .cmd(cmd)
   );

   // parameter slots armed by a base byte
   always_comb begin
      new_pend = '0;
      case (grp)
         GRP0: begin
            new_pend[S_A_LO] = wr_data[3];
            new_pend[S_A_HI] = wr_data[4];
            new_pend[S_L_LO] = wr_data[5];
            new_pend[S_L_HI] = wr_data[6];
         end
         GRP1: new_pend[S_TIM_A] = wr_data[6];
         GRP2: new_pend[S_TIM_B] = wr_data[6];
         GRP3: begin
            new_pend[S_G3_A] = wr_data[3];
            new_pend[S_G3_B] = wr_data[4];
         end
         GRP4: begin
            new_pend[S_B_LO] = wr_data[2];
            new_pend[S_B_HI] = wr_data[3];
         end
         GRP6: new_pend[S_RMASK] = cmd.mask_nxt;
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q       <= '0;
         puls_q       <= '0;
         dir_a_to_b   <= 1'b0;
         porta_addr   <= '0;
         block_len    <= '0;
         porta_io     <= 1'b0;
         porta_step   <= '0;
         porta_cycles <= '0;
         portb_io     <= 1'b0;
         portb_step   <= '0;
         portb_cycles <= '0;
         portb_addr   <= '0;
         prescale     <= '0;
         burst_mode   <= 1'b0;
         auto_restart <= 1'b0;
         ce_wait_mux  <= 1'b0;
         read_mask    <= MASK_RST;
      end else begin
         puls_q <= '0;
         if (wr_en) begin
            if (pend_any) begin
               pend_q <= (pend_q & ~(SLOT_ONE << slot_idx)) |
                         ((slot_idx == S_TIM_B && wr_data[5]) ? (SLOT_ONE << S_PRESC) : '0);
               case (slot_idx)
                  S_A_LO:  porta_addr[DATA_W-1:0]  <= wr_data;
                  S_A_HI:  porta_addr[AW-1:DATA_W] <= wr_data;
                  S_L_LO:  block_len[DATA_W-1:0]   <= wr_data;
                  S_L_HI:  block_len[AW-1:DATA_W]  <= wr_data;
                  S_TIM_A: porta_cycles <= wr_data[1:0];
                  S_TIM_B: portb_cycles <= wr_data[1:0];
                  S_PRESC: prescale     <= wr_data[PRESC_W-1:0];
                  S_B_LO:  portb_addr[DATA_W-1:0]  <= wr_data;
                  S_B_HI:  portb_addr[AW-1:DATA_W] <= wr_data;
                  S_RMASK: read_mask    <= wr_data[MASK_W-1:0];
                  default: ; // group 3 mask/match bytes are accepted and dropped
               endcase
            end else begin
               pend_q <= new_pend;
               case (grp)
                  GRP0: dir_a_to_b <= wr_data[2];
                  GRP1: begin
                     porta_io   <= wr_data[3];
                     porta_step <= wr_data[5:4];
                  end
                  GRP2: begin
                     portb_io   <= wr_data[3];
                     portb_step <= wr_data[5:4];
                  end
                  GRP3: puls_q.en <= wr_data[6];
                  GRP4: burst_mode <= (wr_data[6:5] == 2'b10);
                  GRP5: begin
                     auto_restart <= wr_data[5];
                     ce_wait_mux  <= wr_data[4];
                  end
                  GRP6: begin
                     puls_q <= cmd.p;
                     if (cmd.p.rst_all) begin
                        porta_cycles <= '0;
                        portb_cycles <= '0;
                        prescale     <= '0;
                     end
                     if (cmd.p.rst_ta) porta_cycles <= '0;
                     if (cmd.p.rst_tb) begin
                        portb_cycles <= '0;
                        prescale     <= '0;
                     end
                  end
                  default: ;
               endcase
            end
         end
      end
   end

   assign cmd_reset         = puls_q.rst_all;
   assign cmd_reset_ta      = puls_q.rst_ta;
   assign cmd_reset_tb      = puls_q.rst_tb;
   assign cmd_load          = puls_q.load;
   assign cmd_continue      = puls_q.resume;
   assign cmd_enable        = puls_q.en;
   assign cmd_disable       = puls_q.dis;
   assign cmd_rd_status     = puls_q.rd_stat;
   assign cmd_reinit_status = puls_q.re_stat;
   assign cmd_rd_seq        = puls_q.rd_seq;

   // R7
   pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd_reset, cmd_reset_ta, cmd_reset_tb, cmd_load, cmd_continue,
                cmd_enable, cmd_disable, cmd_rd_status, cmd_reinit_status, cmd_rd_seq}));

   // R7
   pulse_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_load || cmd_continue || cmd_enable || cmd_disable || cmd_reset) |-> $past(wr_en));

   // R8
   rmask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en) |-> $stable(read_mask));

   // R9
   presc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en) |-> $stable(prescale));

   // R11
   reset_cmd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_reset |-> (pend_q == '0));
endmodule

// File: tb/sim_dma_cmd_seq.sv
module sim_dma_cmd_seq;
   timeunit 1ns;
   timeprecision 100ps;

   localparam logic [9:0] P_NONE = 10'h000;
   localparam logic [9:0] P_RST  = 10'h200;
   localparam logic [9:0] P_RTA  = 10'h100;
   localparam logic [9:0] P_RTB  = 10'h080;
   localparam logic [9:0] P_LOAD = 10'h040;
   localparam logic [9:0] P_RES  = 10'h020;
   localparam logic [9:0] P_EN   = 10'h010;
   localparam logic [9:0] P_DIS  = 10'h008;
   localparam logic [9:0] P_RSTA = 10'h004;
   localparam logic [9:0] P_REST = 10'h002;
   localparam logic [9:0] P_RSEQ = 10'h001;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic dir_a_to_b, porta_io, portb_io, burst_mode, auto_restart, ce_wait_mux;
   logic [15:0] porta_addr, block_len, portb_addr;
   logic [1:0] porta_step, porta_cycles, portb_step, portb_cycles;
   logic [7:0] prescale;
   logic [6:0] read_mask;
   logic c_rst, c_rta, c_rtb, c_load, c_cont, c_en, c_dis, c_rs, c_re, c_rq;

   int errors = 0;
   int checks = 0;
   logic [9:0] exp_q[$];
   string tag_q[$];
   event mon_ev;

   always #2.5 clk = ~clk;

   dma_cmd_seq u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .dir_a_to_b(dir_a_to_b), .porta_addr(porta_addr), .block_len(block_len),
      .porta_io(porta_io), .porta_step(porta_step), .porta_cycles(porta_cycles),
      .portb_io(portb_io), .portb_step(portb_step), .portb_cycles(portb_cycles),
      .portb_addr(portb_addr), .prescale(prescale), .burst_mode(burst_mode),
      .auto_restart(auto_restart), .ce_wait_mux(ce_wait_mux), .read_mask(read_mask),
      .cmd_reset(c_rst), .cmd_reset_ta(c_rta), .cmd_reset_tb(c_rtb),
      .cmd_load(c_load), .cmd_continue(c_cont), .cmd_enable(c_en),
      .cmd_disable(c_dis), .cmd_rd_status(c_rs), .cmd_reinit_status(c_re),
      .cmd_rd_seq(c_rq)
   );

   wire [9:0] pulses = {c_rst, c_rta, c_rtb, c_load, c_cont, c_en, c_dis, c_rs, c_re, c_rq};

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // driver: one byte, expected pulse vector into the scoreboard
   task automatic wr(input logic [7:0] d, input logic [9:0] expp, input string tag);
      exp_q.push_back(expp);
      tag_q.push_back(tag);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      -> mon_ev;
   endtask

   // monitor: compare the pulse vector in the cycle after each write
   initial begin
      forever begin
         @(mon_ev);
         if (exp_q.size() != 0) begin
            logic [9:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({t, " pulses"}, 32'(pulses), 32'(e));
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      check("R12 read_mask", 32'(read_mask), 32'h7F);
      check("R12 prescale", 32'(prescale), 0);
      check("R12 block_len", 32'(block_len), 0);
      check("R12 pulses", 32'(pulses), 0);

      // R2 full group 0 stream
      wr(8'h7D, P_NONE, "R2 base");
      wr(8'h34, P_NONE, "R2 a_lo");
      wr(8'hC3, P_NONE, "R11 a_hi looks like reset");
      wr(8'h78, P_NONE, "R2 l_lo");
      wr(8'h56, P_NONE, "R2 l_hi");
      check("R2 porta", 32'(porta_addr), 32'hC334);
      check("R2 len", 32'(block_len), 32'h5678);
      check("R2 dir", 32'(dir_a_to_b), 1);
      // R2 sparse flags: bits 3 and 6 only
      wr(8'h49, P_NONE, "R2 sparse base");
      wr(8'hAB, P_NONE, "R2 sparse a_lo");
      wr(8'h9A, P_NONE, "R2 sparse l_hi");
      check("R2 sparse porta", 32'(porta_addr), 32'hC3AB);
      check("R2 sparse len", 32'(block_len), 32'h9A78);
      check("R2 sparse dir", 32'(dir_a_to_b), 0);
      // R11 next byte is a base byte again
      wr(8'hCF, P_LOAD, "R11 back to base");

      // R3 group 1
      wr(8'h54, P_NONE, "R3 g1 base");
      wr(8'h02, P_NONE, "R3 g1 timing");
      check("R3 a_step", 32'(porta_step), 1);
      check("R3 a_cyc", 32'(porta_cycles), 2);
      check("R3 a_io", 32'(porta_io), 0);
      wr(8'h0C, P_NONE, "R9 g1 no timing");
      check("R3 a_io set", 32'(porta_io), 1);
      check("R9 a_cyc kept", 32'(porta_cycles), 2);

      // R4 group 2 with nested prescaler
      wr(8'h68, P_NONE, "R4 g2 base");
      wr(8'h21, P_NONE, "R4 g2 timing");
      wr(8'h37, P_NONE, "R4 prescaler");
      check("R4 prescale", 32'(prescale), 32'h37);
      check("R3 b_cyc", 32'(portb_cycles), 1);
      check("R3 b_step", 32'(portb_step), 2);
      check("R3 b_io", 32'(portb_io), 1);
      wr(8'h50, P_NONE, "R9 g2 base");
      wr(8'h02, P_NONE, "R9 g2 timing no presc");
      check("R9 prescale kept", 32'(prescale), 32'h37);
      check("R9 b_cyc", 32'(portb_cycles), 2);
      wr(8'h87, P_EN, "R11 base after timing");

      // R5 group 4
      wr(8'hCD, P_NONE, "R5 g4 base");
      wr(8'h00, P_NONE, "R5 b_lo");
      wr(8'hC0, P_NONE, "R5 b_hi");
      check("R5 portb", 32'(portb_addr), 32'hC000);
      check("R5 burst", 32'(burst_mode), 1);
      wr(8'hA1, P_NONE, "R5 mode 01");
      check("R5 continuous", 32'(burst_mode), 0);
      check("R5 portb kept", 32'(portb_addr), 32'hC000);
      wr(8'hC1, P_NONE, "R5 mode 10");
      check("R5 burst again", 32'(burst_mode), 1);
      wr(8'h81, P_NONE, "R5 mode 00");
      check("R5 mode 00 continuous", 32'(burst_mode), 0);
      wr(8'hC1, P_NONE, "R5 mode 10 b");
      wr(8'hE1, P_NONE, "R5 mode 11");
      check("R5 mode 11 continuous", 32'(burst_mode), 0);

      // R6 group 5
      wr(8'hB2, P_NONE, "R6 set");
      check("R6 restart", 32'(auto_restart), 1);
      check("R6 cewait", 32'(ce_wait_mux), 1);
      wr(8'h82, P_NONE, "R6 clear");
      check("R6 restart clr", 32'(auto_restart), 0);
      check("R6 cewait clr", 32'(ce_wait_mux), 0);

      // R1 unmatched bytes
      wr(8'hB2, P_NONE, "R1 setup");
      wr(8'hC6, P_NONE, "R1 unmatched C6");
      wr(8'h86, P_NONE, "R1 unmatched 86");
      check("R1 restart kept", 32'(auto_restart), 1);
      wr(8'h04, P_NONE, "R1 g1 empty");
      wr(8'hD3, P_RES, "R1 base after empty");

      // R7 commands
      wr(8'hD3, P_RES, "R7 continue");
      wr(8'h83, P_DIS, "R7 disable");
      wr(8'hBF, P_RSTA, "R7 read status");
      wr(8'h8B, P_REST, "R7 reinit status");
      wr(8'hA7, P_RSEQ, "R7 read seq");
      wr(8'hB3, P_NONE, "R7 unknown B3");
      wr(8'hAB, P_NONE, "R7 unknown AB");

      // R8 read mask
      wr(8'hBB, P_NONE, "R8 mask follows");
      wr(8'h87, P_NONE, "R8 mask byte");
      check("R8 read_mask", 32'(read_mask), 32'h07);

      // R9 timing resets
      wr(8'hC7, P_RTA, "R9 reset A timing");
      check("R9 a_cyc clr", 32'(porta_cycles), 0);
      check("R9 b_cyc kept", 32'(portb_cycles), 2);
      wr(8'hCB, P_RTB, "R9 reset B timing");
      check("R9 b_cyc clr", 32'(portb_cycles), 0);
      check("R9 presc clr", 32'(prescale), 0);
      wr(8'h40, P_NONE, "R9 g2 base");
      wr(8'h23, P_NONE, "R9 g2 timing");
      wr(8'h55, P_NONE, "R9 presc");
      wr(8'h44, P_NONE, "R9 g1 base");
      wr(8'h01, P_NONE, "R9 g1 timing");
      wr(8'hC3, P_RST, "R9 full reset");
      check("R9 rst a_cyc", 32'(porta_cycles), 0);
      check("R9 rst b_cyc", 32'(portb_cycles), 0);
      check("R9 rst presc", 32'(prescale), 0);
      check("R9 rst mask kept", 32'(read_mask), 32'h07);

      // R10 group 3
      wr(8'hC0, P_EN, "R10 enable bit");
      wr(8'h98, P_NONE, "R10 g3 flags");
      wr(8'hCF, P_NONE, "R10 discarded 1");
      wr(8'h87, P_NONE, "R10 discarded 2");
      check("R10 len kept", 32'(block_len), 32'h9A78);
      wr(8'h87, P_EN, "R10 base after discard");

      repeat (2) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule